// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two direction predictors and picks between them. The first component is per-branch. A table indexed by the branch PC keeps each branch's own recent outcomes, and that pattern selects one entry in a pool of 3-bit saturating counters shared by all branches. The second component is path-based. A shift register holds the outcomes of the most recent branches in the program, and its value selects a 2-bit saturating counter. A third table of 2-bit counters is indexed by the same path history. It learns which component to trust, and its upper bit steers the output multiplexer.

The fetch side presents a PC and reads all four prediction signals in the same cycle, since the read path is combinational from the stored state. The execution side reports a resolved branch later. It gives the branch PC, the real outcome and the two component predictions it captured at fetch. That one cycle then trains both component counters, moves the selector only when the two components disagreed in correctness, and shifts the outcome into the branch's own history and into the path history. The tables are indexed with the histories current at resolution time, so exact training assumes that branches resolve in fetch order before the next lookup of the same state.

Top module: `tourn_pred`

## Requirements
- R1: After reset, every per-branch history and the path history are all zeros, every 3-bit counter holds 3 (weakly not taken), and every 2-bit direction and selector counter holds 1. So for any PC: pred_local=0, pred_global=0, pred_choice=0, pred_taken=0.
- R2: pred_local is bit 2 of the 3-bit counter selected by the per-branch history of the entry at pred_pc[PC_LSB +: LHT_IDX_W]. On a resolve, the counter selected by res_pc's history steps up by one for taken and down by one for not taken, and it holds at 7 and at 0.
- R3: pred_global is bit 1 of the 2-bit counter selected by the path history. On a resolve, that counter steps toward the outcome and holds at 3 and at 0.
- R4: pred_choice is bit 1 of the selector counter selected by the path history. pred_taken equals pred_global when pred_choice is 1 and pred_local when it is 0.
- R5: On a resolve, the selector counter at the path history steps up (saturating at 3) when res_global matches res_taken and res_local does not. It steps down (saturating at 0) when res_local matches and res_global does not. It holds when both match or both miss.
- R6: On a resolve, the per-branch history entry of res_pc shifts left by one, with res_taken entering bit 0 and the oldest bit dropped.
- R7: On a resolve, the path history shifts left by one, with res_taken entering bit 0.
- R8: When a lookup and a resolve land in the same cycle, even for the same PC, the prediction reflects the state before the update. The update is seen from the next cycle.
- R9: While res_valid is 0, no table or history changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC looked up this cycle |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Per-branch component prediction |
| pred_global | output | 1 | Path-history component prediction |
| pred_choice | output | 1 | Selector bit, 1 means the path component is used |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_local | input | 1 | Per-branch prediction captured at fetch |
| res_global | input | 1 | Path prediction captured at fetch |

## Verification
The lookup and the training update can fall in the same cycle, and often on the very entries being read. The bench provokes this by resolving a branch while it looks up the same PC, and it repeats this through long runs of taken outcomes and through a random stream where lookup and resolve PCs often alias. Each lookup is judged against a model of the rules whose state is advanced only after that cycle's expected values are recorded. So a design that forwards the update into the same-cycle read, or that drops or delays it, mismatches on the following lookups.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Selector training: move only when exactly one component was right.
    function automatic logic sel_move(input logic outcome, input logic p_loc, input logic p_glb);
        return (p_loc == outcome) != (p_glb == outcome);
    endfunction

    // Direction of the move: toward the path component when it was the right one.
    function automatic logic sel_toward_global(input logic outcome, input logic p_glb);
        return p_glb == outcome;
    endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int IDX_W = 4,
    parameter int CW    = 2,
    parameter logic [CW-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW-1:0]    rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] ctr_q [DEPTH];
    logic [CW-1:0] cur;

    assign rd_ctr = ctr_q[rd_idx];
    assign cur    = ctr_q[upd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT;
        end else if (upd_en) begin
            if (upd_up && cur != CMAX)
                ctr_q[upd_idx] <= cur + 1'b1;
            else if (!upd_up && cur != '0)
                ctr_q[upd_idx] <= cur - 1'b1;
        end
    end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W = 4,
    parameter int HW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HW-1:0]    rd_hist,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_bit,
    output logic [HW-1:0]    upd_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HW-1:0] hist_q [DEPTH];

    assign rd_hist  = hist_q[rd_idx];
    assign upd_hist = hist_q[upd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (upd_en) begin
            hist_q[upd_idx] <= {upd_hist[HW-2:0], upd_bit};
        end
    end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LHT_IDX_W = 4,
    parameter int LHIST_W   = 4,
    parameter int GHIST_W   = 5,
    parameter int LCTR_W    = 3,
    parameter int GCTR_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    output logic            pred_choice,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_local,
    input  logic            res_global
);
    import tp_pkg::*;

    localparam logic [LCTR_W-1:0] L_INIT = {1'b0, {(LCTR_W-1){1'b1}}};
    localparam logic [GCTR_W-1:0] G_INIT = {1'b0, {(GCTR_W-1){1'b1}}};

    logic [LHT_IDX_W-1:0] p_idx, r_idx;
    logic [LHIST_W-1:0]   p_lhist, r_lhist;
    logic [GHIST_W-1:0]   ghist_q;
    logic [LCTR_W-1:0]    l_ctr;
    logic [GCTR_W-1:0]    g_ctr, c_ctr;
    logic                 sel_en, sel_up;
    logic                 unused_pc_bits;

    assign p_idx = pred_pc[PC_LSB +: LHT_IDX_W];
    assign r_idx = res_pc[PC_LSB +: LHT_IDX_W];
    assign unused_pc_bits = ^{pred_pc, res_pc};

    tp_hist_table #(.IDX_W(LHT_IDX_W), .HW(LHIST_W)) u_lht (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(p_idx), .rd_hist(p_lhist),
        .upd_en(res_valid), .upd_idx(r_idx), .upd_bit(res_taken), .upd_hist(r_lhist)
    );

    tp_sat_table #(.IDX_W(LHIST_W), .CW(LCTR_W), .INIT(L_INIT)) u_lctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(p_lhist), .rd_ctr(l_ctr),
        .upd_en(res_valid), .upd_idx(r_lhist), .upd_up(res_taken)
    );

    tp_sat_table #(.IDX_W(GHIST_W), .CW(GCTR_W), .INIT(G_INIT)) u_gctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist_q), .rd_ctr(g_ctr),
        .upd_en(res_valid), .upd_idx(ghist_q), .upd_up(res_taken)
    );

    assign sel_en = res_valid && sel_move(res_taken, res_local, res_global);
    assign sel_up = sel_toward_global(res_taken, res_global);

    tp_sat_table #(.IDX_W(GHIST_W), .CW(GCTR_W), .INIT(G_INIT)) u_choice (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist_q), .rd_ctr(c_ctr),
        .upd_en(sel_en), .upd_idx(ghist_q), .upd_up(sel_up)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ghist_q <= '0;
        else if (res_valid)
            ghist_q <= {ghist_q[GHIST_W-2:0], res_taken};
    end

    always_comb begin
        pred_local  = l_ctr[LCTR_W-1];
        pred_global = g_ctr[GCTR_W-1];
        pred_choice = c_ctr[GCTR_W-1];
        pred_taken  = pred_choice ? pred_global : pred_local;
    end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int PC_W    = 32,
    parameter int LHIST_W = 4,
    parameter int GHIST_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               res_valid,
    input logic [PC_W-1:0]    res_pc,
    input logic               res_taken,
    input logic [GHIST_W-1:0] ghist_q,
    input logic [LHIST_W-1:0] r_lhist
);
    // R1: path history is cleared by reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> ghist_q == '0);

    // R7: path history shifts in the outcome
    assert_path_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(res_taken)});

    // R9: no resolve, no history movement
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ghist_q));

    // R6: per-branch history of a repeated PC shifts in the outcome
    assert_branch_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid ##1 (res_pc == $past(res_pc)) |->
            r_lhist == {$past(r_lhist[LHIST_W-2:0]), $past(res_taken)});
endmodule

bind tourn_pred tp_checker #(.PC_W(PC_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) u_tp_checker (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .ghist_q(ghist_q), .r_lhist(r_lhist)
);

// File: tb/tourn_pred_bench.sv
module tourn_pred_bench;
    localparam int CLK_P = 10;
    localparam int LI_W = 4, LH_W = 4, GH_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] pred_pc = '0, res_pc = '0;
    logic res_valid = 1'b0, res_taken = 1'b0, res_local = 1'b0, res_global = 1'b0;
    logic pred_taken, pred_local, pred_global, pred_choice;

    always #(CLK_P/2) clk = ~clk;

    tourn_pred #(.PC_W(32), .PC_LSB(2), .LHT_IDX_W(LI_W), .LHIST_W(LH_W),
                 .GHIST_W(GH_W), .LCTR_W(3), .GCTR_W(2)) u_tourn_pred (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_local(pred_local),
        .pred_global(pred_global), .pred_choice(pred_choice),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_local(res_local), .res_global(res_global)
    );

    typedef struct { logic tk; logic lo; logic gl; logic ch; string req; } exp_t;
    exp_t q[$];
    int n_cmp = 0, n_bad = 0;

    // reference state built from the requirements
    int lht [1<<LI_W];
    int lctr[1<<LH_W];
    int gctr[1<<GH_W];
    int chc [1<<GH_W];
    int gh;

    function automatic int sat(input int v, input logic up, input int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic model_reset();
        foreach (lht[i])  lht[i]  = 0;
        foreach (lctr[i]) lctr[i] = 3;
        foreach (gctr[i]) gctr[i] = 1;
        foreach (chc[i])  chc[i]  = 1;
        gh = 0;
    endtask

    task automatic step(input logic [31:0] ppc, input logic rv, input logic [31:0] rpc,
                        input logic tk, input logic p0, input logic p1, input string req);
        exp_t e;
        int li, lh;
        @(negedge clk);
        pred_pc = ppc; res_valid = rv; res_pc = rpc;
        res_taken = tk; res_local = p0; res_global = p1;
        lh = lht[(ppc >> 2) & ((1<<LI_W)-1)];
        e.lo = lctr[lh][2];
        e.gl = gctr[gh][1];
        e.ch = chc[gh][1];
        e.tk = e.ch ? e.gl : e.lo;
        e.req = req;
        q.push_back(e);
        if (rv) begin
            li = (rpc >> 2) & ((1<<LI_W)-1);
            lh = lht[li];
            lctr[lh] = sat(lctr[lh], tk, 7);
            gctr[gh] = sat(gctr[gh], tk, 3);
            if ((p0 == tk) != (p1 == tk)) chc[gh] = sat(chc[gh], p1 == tk, 3);
            lht[li] = ((lh << 1) | int'(tk)) & ((1<<LH_W)-1);
            gh = ((gh << 1) | int'(tk)) & ((1<<GH_W)-1);
        end
    endtask

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, a quarter period after the drive
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                cmp(e.req, "pred_local (R2)",  pred_local,  e.lo);
                cmp(e.req, "pred_global (R3)", pred_global, e.gl);
                cmp(e.req, "pred_choice (R5)", pred_choice, e.ch);
                cmp(e.req, "pred_taken (R4)",  pred_taken,  e.tk);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state for several PCs
        step(32'h0, 0, 0, 0, 0, 0, "R1");
        step(32'h4, 0, 0, 0, 0, 0, "R1");
        step(32'h3c, 0, 0, 0, 0, 0, "R1");
        // R2 R6 R8: train one branch taken while looking it up in the same cycle
        for (int i = 0; i < 8; i++) step(32'h40, 1, 32'h40, 1, 1, 1, "R2 R6 R8");
        for (int i = 0; i < 6; i++) step(32'h40, 1, 32'h40, 0, 0, 0, "R2 R6 R8");
        // R3 R7: path training via a different branch, then read it back through another PC
        for (int i = 0; i < 7; i++) step(32'h8, 1, 32'h48, 1, 1, 1, "R3 R7");
        // R5 R4: path component right, local wrong -> selector moves toward global
        for (int i = 0; i < 4; i++) step(32'h8, 1, 32'h48, 1, 0, 1, "R5 R4");
        // R5: both right / both wrong -> hold
        for (int i = 0; i < 3; i++) step(32'h8, 1, 32'h48, 1, 1, 1, "R5");
        for (int i = 0; i < 3; i++) step(32'h8, 1, 32'h48, 1, 0, 0, "R5");
        // R5: local right, path wrong -> selector moves back
        for (int i = 0; i < 4; i++) step(32'h8, 1, 32'h48, 1, 1, 0, "R5 R4");
        // R9: resolve fields toggle but res_valid is low
        for (int i = 0; i < 5; i++) step(32'h8, 0, 32'h8, i[0], ~i[0], i[0], "R9");
        // mixed stream, lookup and resolve PCs aliasing often
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] a, b;
            a = ($urandom % 8) << 2;
            b = ($urandom % 4 == 0) ? a : (($urandom % 8) << 2);
            step(a, ($urandom % 4) != 0, b, $urandom % 3 != 0, $urandom % 2, $urandom % 2, "R2 R3 R4 R5 R8");
        end
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule